// File: doc/BRIEF.md
# Fabric Error Detect and Capture Unit

This unit collects error events reported by an interconnect fabric and makes them visible to software through a small bank of 32-bit registers. Each of four error classes arrives as a single-cycle pulse. A pulse sets a sticky pending bit unless its class has been masked off. The first recorded error also freezes its 40-bit address, 8-bit source ID, 5-bit type code and a 32-bit attribute word into capture registers. Later errors still set their pending bits. They cannot overwrite the captured record until software re-arms it.

An interrupt-enable mask chooses which pending classes drive the level interrupt output. The detection-disable mask is held separately and decides which classes are recorded at all. Software reads the detect register, services the error and writes the same value back. Ones clear the matching pending bits, and a one in the capture-valid position re-arms capture.

The register port makes single-cycle accesses and never stalls. A request with `reg_wr` low returns `reg_rdata` together with a one-cycle `reg_rvalid` strobe at the next clock edge, so no back-pressure exists on either side. The error event inputs are plain pulses with no handshake.

Top module: `ferr_unit`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: A pulse on `err_pulse[i]` whose disable bit is 0 sets detect bit i at offset 0x00 at the next clock edge. The classes are: bit 0 local access error, bit 1 coherency violation, bit 2 unavailable target, bit 3 multicast stash. The bit stays set until software clears it.
- R3: When bit i of the disable register (offset 0x04, bits 3:0) is 1, a pulse on `err_pulse[i]` sets no detect bit and loads no capture register. The disable register reads back its 4-bit value in bits 3:0.
- R4: A write to offset 0x00 clears each detect bit 3:0 whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R5: When capture-valid is 0, the first recorded error loads the capture registers and sets detect bit 31. Detect bits 30:26 then read the 5-bit type. Offset 0x10 bits 7:0 read address bits 39:32, and offset 0x14 reads address bits 31:0. Offset 0x0C bits 25:18 read the source ID, and offset 0x18 reads the attribute word.
- R6: While capture-valid is 1, later errors set their detect bits but leave every capture register unchanged.
- R7: Writing 1 to detect bit 31 clears capture-valid, and detect bits 30:26 then read 0. The next recorded error is captured again.
- R8: When a new error event and a software clear hit the same detect bit in the same cycle, the bit stays set. When an error is recorded in the same cycle that bit 31 is written 1, its data is captured and capture-valid stays 1.
- R9: `irq` is registered. It equals the OR over bits 3:0 of (detect AND interrupt-enable), where interrupt-enable is offset 0x08 bits 3:0. It reflects the registers as they stand one clock edge earlier.
- R10: `reg_rvalid` pulses one cycle after each read request, and `reg_rdata` holds the addressed register's value from before that edge. Unmapped word offsets read 0, and writes to the capture registers (0x0C to 0x18) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access request this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data strobe, one cycle after the request |
| err_pulse | input | 4 | One single-cycle pulse per error class |
| err_addr | input | 40 | Address of the erring transaction |
| err_src | input | 8 | Source ID of the erring transaction |
| err_type | input | 5 | Type code of the erring transaction |
| err_attr2 | input | 32 | Extra attribute word |
| irq | output | 1 | Level interrupt |

## Verification
An error pulse applied before clock edge k is visible in the detect and capture registers from edge k. `irq` follows at edge k+1, and read data for a request sampled at edge k arrives with `reg_rvalid` just after that same edge. The bench drives every input at the falling edge and samples at the falling edge. A monitor compares each read result with a queued expectation in the half cycle after the request's edge. Interrupt checks wait one further falling edge after the register change that causes them.

// File: rtl/ferr_pkg.sv
package ferr_pkg;
  localparam int NCLS     = 4;
  localparam int DW       = 32;
  localparam int AW       = 40;
  localparam int SW       = 8;
  localparam int TW       = 5;
  localparam int OFFW     = 5;
  localparam int CAPV_BIT = 31;
  localparam int TYPE_LSB = 26;
  localparam int SRC_LSB  = 18;

  typedef enum logic [2:0] {
    RS_DET   = 3'd0,
    RS_DIS   = 3'd1,
    RS_IEN   = 3'd2,
    RS_ATTR  = 3'd3,
    RS_ADDRH = 3'd4,
    RS_ADDRL = 3'd5,
    RS_ATTR2 = 3'd6,
    RS_NONE  = 3'd7
  } rsel_e;

  function automatic rsel_e decode_off(input logic [OFFW-1:0] off);
    if (off[1:0] != 2'b00) return RS_NONE;
    case (off[4:2])
      3'd0: return RS_DET;
      3'd1: return RS_DIS;
      3'd2: return RS_IEN;
      3'd3: return RS_ATTR;
      3'd4: return RS_ADDRH;
      3'd5: return RS_ADDRL;
      3'd6: return RS_ATTR2;
      default: return RS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ferr_regif.sv
module ferr_regif
  import ferr_pkg::*;
#(
  parameter int DWP  = DW,
  parameter int OFFP = OFFW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_sel,
  input  logic            reg_wr,
  input  logic [OFFP-1:0] reg_addr,
  input  logic [DWP-1:0]  det_word,
  input  logic [DWP-1:0]  dis_word,
  input  logic [DWP-1:0]  ien_word,
  input  logic [DWP-1:0]  attr_word,
  input  logic [DWP-1:0]  addrh_word,
  input  logic [DWP-1:0]  addrl_word,
  input  logic [DWP-1:0]  attr2_word,
  output logic            wr_det,
  output logic            wr_dis,
  output logic            wr_ien,
  output logic [DWP-1:0]  reg_rdata,
  output logic            reg_rvalid
);
  rsel_e          which;
  logic [DWP-1:0] rmux;

  always_comb begin
    which  = decode_off(reg_addr);
    wr_det = reg_sel && reg_wr && (which == RS_DET);
    wr_dis = reg_sel && reg_wr && (which == RS_DIS);
    wr_ien = reg_sel && reg_wr && (which == RS_IEN);
  end

  always_comb begin
    case (which)
      RS_DET:   rmux = det_word;
      RS_DIS:   rmux = dis_word;
      RS_IEN:   rmux = ien_word;
      RS_ATTR:  rmux = attr_word;
      RS_ADDRH: rmux = addrh_word;
      RS_ADDRL: rmux = addrl_word;
      RS_ATTR2: rmux = attr2_word;
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_sel && !reg_wr;
      if (reg_sel && !reg_wr) reg_rdata <= rmux;
    end
  end
endmodule

// File: rtl/ferr_cfg_reg.sv
module ferr_cfg_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wval,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (we) q <= wval;
  end
endmodule

// File: rtl/ferr_detect.sv
module ferr_detect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] dis,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic         clr_cap,
  output logic [N-1:0] det_q,
  output logic         cap_vld_q,
  output logic         cap_load
);
  logic [N-1:0] taken;

  assign taken    = evt & ~dis;
  assign cap_load = (|taken) && (!cap_vld_q || clr_cap);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) det_q[i] <= 1'b0;
      else if (taken[i]) det_q[i] <= 1'b1;
      else if (clr_wr && clr_mask[i]) det_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cap_vld_q <= 1'b0;
    else if (cap_load) cap_vld_q <= 1'b1;
    else if (clr_cap) cap_vld_q <= 1'b0;
  end
endmodule

// File: rtl/ferr_capture.sv
module ferr_capture #(
  parameter int AWP = 40,
  parameter int SWP = 8,
  parameter int TWP = 5,
  parameter int XWP = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AWP-1:0] in_addr,
  input  logic [SWP-1:0] in_src,
  input  logic [TWP-1:0] in_type,
  input  logic [XWP-1:0] in_attr2,
  output logic [AWP-1:0] addr_q,
  output logic [SWP-1:0] src_q,
  output logic [TWP-1:0] type_q,
  output logic [XWP-1:0] attr2_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      src_q   <= '0;
      type_q  <= '0;
      attr2_q <= '0;
    end else if (load) begin
      addr_q  <= in_addr;
      src_q   <= in_src;
      type_q  <= in_type;
      attr2_q <= in_attr2;
    end
  end
endmodule

// File: rtl/ferr_unit.sv
module ferr_unit
  import ferr_pkg::*;
#(
  parameter int N    = NCLS,
  parameter int AWP  = AW,
  parameter int SWP  = SW,
  parameter int TWP  = TW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_sel,
  input  logic            reg_wr,
  input  logic [OFFW-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            reg_rvalid,
  input  logic [N-1:0]    err_pulse,
  input  logic [AWP-1:0]  err_addr,
  input  logic [SWP-1:0]  err_src,
  input  logic [TWP-1:0]  err_type,
  input  logic [DW-1:0]   err_attr2,
  output logic            irq
);
  localparam int AHW = AWP - 32;

  logic          wr_det, wr_dis, wr_ien;
  logic [N-1:0]  det_q, dis_q, ien_q;
  logic          cap_vld_q, cap_load;
  logic [AWP-1:0] cap_addr;
  logic [SWP-1:0] cap_src;
  logic [TWP-1:0] cap_type;
  logic [DW-1:0]  cap_attr2;
  logic [DW-1:0]  det_word, dis_word, ien_word;
  logic [DW-1:0]  attr_word, addrh_word, addrl_word;

  ferr_regif #(.DWP(DW), .OFFP(OFFW)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .det_word(det_word), .dis_word(dis_word),
    .ien_word(ien_word), .attr_word(attr_word), .addrh_word(addrh_word),
    .addrl_word(addrl_word), .attr2_word(cap_attr2), .wr_det(wr_det),
    .wr_dis(wr_dis), .wr_ien(wr_ien), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid)
  );

  ferr_cfg_reg #(.W(N)) u_dis (
    .clk(clk), .rst_n(rst_n), .we(wr_dis), .wval(reg_wdata[N-1:0]), .q(dis_q)
  );

  ferr_cfg_reg #(.W(N)) u_ien (
    .clk(clk), .rst_n(rst_n), .we(wr_ien), .wval(reg_wdata[N-1:0]), .q(ien_q)
  );

  ferr_detect #(.N(N)) u_detect (
    .clk(clk), .rst_n(rst_n), .evt(err_pulse), .dis(dis_q),
    .clr_wr(wr_det), .clr_mask(reg_wdata[N-1:0]),
    .clr_cap(wr_det && reg_wdata[CAPV_BIT]), .det_q(det_q),
    .cap_vld_q(cap_vld_q), .cap_load(cap_load)
  );

  ferr_capture #(.AWP(AWP), .SWP(SWP), .TWP(TWP), .XWP(DW)) u_capture (
    .clk(clk), .rst_n(rst_n), .load(cap_load), .in_addr(err_addr),
    .in_src(err_src), .in_type(err_type), .in_attr2(err_attr2),
    .addr_q(cap_addr), .src_q(cap_src), .type_q(cap_type), .attr2_q(cap_attr2)
  );

  always_comb begin
    det_word = '0;
    det_word[N-1:0] = det_q;
    det_word[TYPE_LSB +: TWP] = cap_vld_q ? cap_type : '0;
    det_word[CAPV_BIT] = cap_vld_q;
    dis_word = '0;
    dis_word[N-1:0] = dis_q;
    ien_word = '0;
    ien_word[N-1:0] = ien_q;
    attr_word = '0;
    attr_word[SRC_LSB +: SWP] = cap_src;
    addrh_word = '0;
    addrh_word[AHW-1:0] = cap_addr[AWP-1:32];
    addrl_word = cap_addr[31:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else irq <= |(det_q & ien_q);
  end
endmodule

// File: rtl/ferr_unit_chk.sv
module ferr_unit_chk #(
  parameter int N = 4,
  parameter int AWP = 40
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_sel,
  input logic           reg_wr,
  input logic [4:0]     reg_addr,
  input logic [31:0]    reg_wdata,
  input logic           reg_rvalid,
  input logic [N-1:0]   err_pulse,
  input logic           irq,
  input logic [N-1:0]   det_q,
  input logic [N-1:0]   dis_q,
  input logic [N-1:0]   ien_q,
  input logic           cap_vld_q,
  input logic [AWP-1:0] cap_addr
);
  logic [N-1:0] clr_m;
  logic [N-1:0] rec_m;
  logic         cap_clr;

  assign clr_m   = (reg_sel && reg_wr && reg_addr == 5'h00) ? reg_wdata[N-1:0] : '0;
  assign cap_clr = reg_sel && reg_wr && reg_addr == 5'h00 && reg_wdata[31];
  assign rec_m   = err_pulse & ~dis_q;

  AST_DET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((det_q & ~clr_m) != 0) |=> ((det_q & $past(det_q & ~clr_m)) == $past(det_q & ~clr_m))); // R2

  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_pulse & dis_q & ~det_q) != 0) |=> ((det_q & $past(err_pulse & dis_q & ~det_q)) == 0)); // R3

  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld_q && !cap_clr) |=> $stable(cap_addr)); // R6

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_m != 0) |=> (((det_q & $past(rec_m)) == $past(rec_m)) && cap_vld_q)); // R8

  AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((det_q & ien_q) != 0) |=> irq); // R9

  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((det_q & ien_q) == 0) |=> !irq); // R9

  AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_wr) |=> reg_rvalid); // R10

  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_sel && !reg_wr) |=> !reg_rvalid); // R10
endmodule

bind ferr_unit ferr_unit_chk #(.N(N), .AWP(AWP)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
  .err_pulse(err_pulse), .irq(irq), .det_q(det_q), .dis_q(dis_q),
  .ien_q(ien_q), .cap_vld_q(cap_vld_q), .cap_addr(cap_addr)
);

// File: tb/ferr_unit_bench.sv
`timescale 1ns/1ps
module ferr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [3:0]  err_pulse = '0;
  logic [39:0] err_addr = '0;
  logic [7:0]  err_src = '0;
  logic [4:0]  err_type = '0;
  logic [31:0] err_attr2 = '0;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ferr_unit u_ferr_unit (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .err_pulse(err_pulse), .err_addr(err_addr),
    .err_src(err_src), .err_type(err_type), .err_attr2(err_attr2), .irq(irq)
  );

  // Monitor: pops the scoreboard whenever read data is strobed
  always @(negedge clk) begin
    if (reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected read strobe: actual %h expected none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic set_evt(input logic [3:0] p, input logic [39:0] a,
                         input logic [7:0] s, input logic [4:0] ty, input logic [31:0] x);
    err_pulse = p; err_addr = a; err_src = s; err_type = ty; err_attr2 = x;
  endtask

  task automatic pulse(input logic [3:0] p, input logic [39:0] a,
                       input logic [7:0] s, input logic [4:0] ty, input logic [31:0] x);
    @(negedge clk);
    set_evt(p, a, s, ty, x);
    @(negedge clk);
    err_pulse = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    for (int i = 0; i < 7; i++) rd(5'(i*4), 32'h0, "R1 register after reset");

    // R2 R5 first error captured
    wr(5'h08, 32'hF);
    pulse(4'b0001, 40'hAB_1234_5678, 8'h5C, 5'h13, 32'hDEAD_BEEF);
    chk_irq(1'b0, "R9 irq one edge after detect");
    @(negedge clk);
    chk_irq(1'b1, "R9 irq raised");
    rd(5'h00, 32'hCC00_0001, "R2 R5 detect word");
    rd(5'h10, 32'h0000_00AB, "R5 address high");
    rd(5'h14, 32'h1234_5678, "R5 address low");
    rd(5'h0C, 32'h0170_0000, "R5 source id");
    rd(5'h18, 32'hDEAD_BEEF, "R5 attribute 2");

    // R6 second error, capture frozen
    pulse(4'b0010, 40'h01_0000_0001, 8'h11, 5'h02, 32'h1);
    rd(5'h00, 32'hCC00_0003, "R6 detect gains bit1");
    rd(5'h14, 32'h1234_5678, "R6 address low frozen");
    rd(5'h0C, 32'h0170_0000, "R6 source frozen");

    // R4 partial clear
    wr(5'h00, 32'h0000_0001);
    rd(5'h00, 32'hCC00_0002, "R4 clear bit0 only");
    // R7 clear rest and capture-valid
    wr(5'h00, 32'h8000_0002);
    rd(5'h00, 32'h0000_0000, "R7 capture valid cleared");
    chk_irq(1'b0, "R9 irq dropped after clear");

    // R3 disabled class
    wr(5'h04, 32'h4);
    rd(5'h04, 32'h0000_0004, "R3 disable readback");
    pulse(4'b0100, 40'h77_7777_7777, 8'h77, 5'h07, 32'h7);
    rd(5'h00, 32'h0000_0000, "R3 disabled class not recorded");
    rd(5'h14, 32'h1234_5678, "R3 disabled class not captured");

    // R7 re-armed capture
    pulse(4'b1000, 40'hFF_CAFE_0000, 8'hA5, 5'h1F, 32'h0);
    rd(5'h00, 32'hFC00_0008, "R7 recapture detect word");
    rd(5'h10, 32'h0000_00FF, "R7 recapture address high");
    rd(5'h14, 32'hCAFE_0000, "R7 recapture address low");
    rd(5'h0C, 32'h0294_0000, "R7 recapture source");
    chk_irq(1'b1, "R9 irq for bit3");
    wr(5'h08, 32'h7);
    @(negedge clk);
    chk_irq(1'b0, "R9 irq masked by enable");
    wr(5'h08, 32'h8);
    @(negedge clk);
    chk_irq(1'b1, "R9 irq re-enabled");

    // R8 event and clear in the same cycle
    @(negedge clk);
    set_evt(4'b1000, 40'h12_0000_0042, 8'h3C, 5'h05, 32'h55);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 5'h00; reg_wdata = 32'h8000_0008;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; err_pulse = '0;
    rd(5'h00, 32'h9400_0008, "R8 event wins over clear");
    rd(5'h14, 32'h0000_0042, "R8 new capture on re-arm");
    rd(5'h18, 32'h0000_0055, "R8 new attribute 2");

    // R10 unmapped offset and read-only capture
    rd(5'h1C, 32'h0, "R10 unmapped offset");
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, 32'h0000_0042, "R10 write to capture ignored");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing read strobes: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule